// File: doc/BRIEF.md
# Low-Activity Scan Chain

This block is a chain of scan storage cells, sized by a parameter, placed between a block's functional inputs and the combinational logic those cells feed. Each cell stores one bit. A shared scan-enable picks what each cell stores: its functional data bit, or the bit arriving on its serial input.

Each cell has two outputs. The functional output goes to downstream logic. The scan output goes to the next cell in the chain. While scan-enable is high, every functional output is held at zero. As a result, the logic fed by the chain sees no transitions while test data moves through the cells. The scan outputs always carry the stored bits, so shifting works whatever the clamp is doing.

The chain runs from one serial input, through cell 0 up to cell N-1, to one serial output. When scan-enable falls, the stored values appear on the functional outputs in the same cycle.

Top module: `lpscan_chain`

## Requirements
- R1: On a rising clock edge, each cell stores its functional data bit when scan_en is 0 (the select value for functional mode) and stores the bit on its serial input when scan_en is 1 (the select value for scan mode).
- R2: No bit of func_q is 1 at any time while scan_en is 1, including while ones are being shifted through the chain.
- R3: Each cell's scan output equals its stored bit in both modes. scan_out equals the bit stored in cell N_CELLS-1 whatever the level of scan_en.
- R4: Shift order runs from scan_in to cell 0, and from cell i to cell i+1. After N_CELLS shift edges, the first bit shifted in sits in cell N_CELLS-1 (func_q bit N_CELLS-1), and the last bit shifted in sits in cell 0 (func_q bit 0).
- R5: With scan_en low at an edge, func_q after that edge equals func_d as it was at that edge. Bit i of func_q comes from cell i.
- R6: func_q shows the stored values as soon as scan_en goes low, within the same cycle and with no clock edge needed.
- R7: Driving rst_n low clears every cell to 0 at once, without waiting for a clock edge. The cells stay cleared until rst_n is released.
- R8: After a functional capture, shifting with scan_en high brings the captured bits out on scan_out, highest cell first: before shift k (counting from 0), scan_out shows the bit captured in cell N_CELLS-1-k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; cells update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all cells |
| scan_en | input | 1 | 1 selects shifting and clamps func_q; 0 selects functional capture |
| scan_in | input | 1 | Serial input to cell 0 |
| func_d | input | N_CELLS | Functional data; bit i feeds cell i |
| func_q | output | N_CELLS | Functional outputs; bit i is cell i, forced to 0 while scan_en is 1 |
| scan_out | output | 1 | Serial output, taken from cell N_CELLS-1 |

## Verification
Functional capture is exercised with alternating patterns (0x55 and 0xAA), all ones and all zeros. These show whether each func_q bit comes from its own func_d bit, or whether neighbouring bits are swapped or stuck. A capture of 0xA5 followed by a full unload shows whether bits leave on scan_out in cell order, highest cell first. An asymmetric serial pattern is then loaded and scan_en dropped, which shows whether the first bit shifted in lands in the top cell and whether the values appear without an extra edge. An all-ones shift, with func_q sampled in both clock phases, shows whether the clamp leaks a one while the chain is full of ones.

// File: rtl/lpscan_pkg.sv
package lpscan_pkg;
  typedef enum logic {
    SEL_FUNC = 1'b0,
    SEL_SCAN = 1'b1
  } lpscan_sel_e;
endpackage

// File: rtl/lpscan_mux.sv
module lpscan_mux
  import lpscan_pkg::*;
(
  input  lpscan_sel_e sel,
  input  logic        func_bit,
  input  logic        scan_bit,
  output logic        mux_bit
);
  always_comb begin
    unique case (sel)
      SEL_SCAN: mux_bit = scan_bit;
      default:  mux_bit = func_bit;
    endcase
  end
endmodule

// File: rtl/lpscan_cell.sv
module lpscan_cell
  import lpscan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  lpscan_sel_e sel,
  input  logic        func_bit,
  input  logic        scan_bit,
  output logic        store_q
);
  logic store_next;

  // next-state: input selection
  lpscan_mux mux_i (
    .sel      (sel),
    .func_bit (func_bit),
    .scan_bit (scan_bit),
    .mux_bit  (store_next)
  );

  // storage register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= 1'b0;
    else        store_q <= store_next;
  end

  // R1: functional capture takes the data bit
  a_r1_func_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_FUNC) |=> (store_q == $past(func_bit)));

  // R1 / R3: in scan mode the stored bit, which is the scan output, follows the serial input
  a_r3_scan_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_SCAN) |=> (store_q == $past(scan_bit)));
endmodule

// File: rtl/lpscan_clamp.sv
module lpscan_clamp
  import lpscan_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  lpscan_sel_e       sel,
  input  logic [WIDTH-1:0]  stored,
  output logic [WIDTH-1:0]  gated
);
  always_comb begin
    if (sel == SEL_SCAN) gated = '0;
    else                 gated = stored;
  end
endmodule

// File: rtl/lpscan_chain.sv
module lpscan_chain
  import lpscan_pkg::*;
#(
  parameter int unsigned N_CELLS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_en,
  input  logic               scan_in,
  input  logic [N_CELLS-1:0] func_d,
  output logic [N_CELLS-1:0] func_q,
  output logic               scan_out
);
  localparam int unsigned LAST = N_CELLS - 1;

  lpscan_sel_e        sel;
  logic [N_CELLS:0]   link;
  logic [N_CELLS-1:0] cell_q;

  assign sel     = lpscan_sel_e'(scan_en);
  assign link[0] = scan_in;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    lpscan_cell cell_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .func_bit (func_d[i]),
      .scan_bit (link[i]),
      .store_q  (cell_q[i])
    );
    assign link[i+1] = cell_q[i];

    if (i > 0) begin : g_order
      // R4: each cell takes the previous cell's bit while shifting
      a_r4_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (cell_q[i] == $past(cell_q[i-1])));
    end
  end

  assign scan_out = link[N_CELLS];

  lpscan_clamp #(.WIDTH(N_CELLS)) clamp_i (
    .sel    (sel),
    .stored (cell_q),
    .gated  (func_q)
  );

  // R2: downstream logic sees only zeros while shifting
  a_r2_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> (func_q == '0));

  // R5: functional capture reaches func_q on the next cycle
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en) |=> (scan_en || (func_q == $past(func_d))));

  // R3: serial output follows the top cell
  a_r3_scan_out: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (scan_out == $past(link[LAST])));
endmodule

// File: tb/lpscan_chain_tb_top.sv
module lpscan_chain_tb_top;
  localparam int N = 8;
  localparam time CLK_PERIOD = 10;

  typedef struct {
    logic [N-1:0] q;
    logic         so;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         scan_en;
  logic         scan_in;
  logic [N-1:0] func_d;
  logic [N-1:0] func_q;
  logic         scan_out;

  item_t        sb_q[$];
  logic [N-1:0] model;
  int           checks = 0;
  int           errors = 0;
  bit           done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpscan_chain #(.N_CELLS(N)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .func_d   (func_d),
    .func_q   (func_q),
    .scan_out (scan_out)
  );

  // Driver: called right after a falling edge. It sets the inputs and pushes
  // the outputs expected before the next rising edge, then advances the model
  // past that edge.
  task automatic step(input logic r, input logic se, input logic si,
                      input logic [N-1:0] d, input string tag);
    item_t it;
    rst_n = r; scan_en = se; scan_in = si; func_d = d;
    if (!r) model = '0;                       // R7 asynchronous clear
    it.q   = se ? '0 : model;                 // R2 clamp, R6 no latency
    it.so  = model[N-1];                      // R3
    it.tag = tag;
    sb_q.push_back(it);
    if (r) begin
      if (se) model = {model[N-2:0], si};     // R4 order
      else    model = d;                      // R1, R5
    end
    @(negedge clk);
  endtask

  // Monitor: a quarter period after each falling edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (func_q !== it.q || scan_out !== it.so) begin
        errors++;
        $display("FAIL %s: func_q=%h scan_out=%b expected func_q=%h scan_out=%b",
                 it.tag, func_q, scan_out, it.q, it.so);
      end
    end
  end

  // R2: clamp is also watched in the high phase of the clock
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n === 1'b1 && scan_en === 1'b1) begin
      checks++;
      if (func_q !== '0) begin
        errors++;
        $display("FAIL R2: func_q=%h while shifting, expected %h", func_q, {N{1'b0}});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] load;
    model = '0;
    rst_n = 1'b0; scan_en = 1'b0; scan_in = 1'b0; func_d = '0;
    @(negedge clk);
    step(1'b0, 1'b0, 1'b0, 8'hFF, "R7");      // reset state
    step(1'b0, 1'b0, 1'b0, 8'hFF, "R7");
    // R1 / R5 functional capture with several patterns
    step(1'b1, 1'b0, 1'b0, 8'h55, "R5");
    step(1'b1, 1'b0, 1'b1, 8'hAA, "R5");
    step(1'b1, 1'b0, 1'b0, 8'hFF, "R1");
    step(1'b1, 1'b0, 1'b1, 8'h00, "R1");
    step(1'b1, 1'b0, 1'b0, 8'hA5, "R5");
    // R8: unload the captured 0xA5, highest cell first, with func_d noise
    for (int k = 0; k < N; k++)
      step(1'b1, 1'b1, 1'b0, 8'h3C ^ 8'(k), "R8");
    // R4: load an asymmetric pattern, first bit is load[N-1]
    load = 8'b1101_0010;
    for (int k = N - 1; k >= 0; k--)
      step(1'b1, 1'b1, load[k], 8'hFF, "R4");
    // R6: drop scan_en, values must show in this same cycle
    step(1'b1, 1'b0, 1'b0, 8'h0F, "R6");
    step(1'b1, 1'b0, 1'b0, 8'h0F, "R5");
    // R2: shift ones through the whole chain and beyond
    for (int k = 0; k < N + 2; k++)
      step(1'b1, 1'b1, 1'b1, 8'h00, "R2");
    step(1'b1, 1'b0, 1'b0, 8'hC3, "R6");
    // R3: scan_out tracks the top cell in functional mode
    step(1'b1, 1'b0, 1'b0, 8'h80, "R3");
    step(1'b1, 1'b0, 1'b0, 8'h7F, "R3");
    step(1'b1, 1'b0, 1'b0, 8'hFF, "R3");
    // R7: asynchronous clear in mid-run, then release
    step(1'b0, 1'b0, 1'b1, 8'hFF, "R7");
    step(1'b1, 1'b0, 1'b0, 8'h5A, "R7");
    step(1'b1, 1'b0, 1'b0, 8'h00, "R5");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule